// File: doc/BRIEF.md
# Per-CPU Highest-Priority Interrupt Selector

This block decides, for every processor in a cluster, which interrupt should be presented next. A scan walks the whole interrupt ID space one ID per clock. For each processor it keeps the best candidate seen so far. A candidate must be pending, enabled and routed to that processor, and it must beat the current best.

The ID space has three classes, each with its own pending storage:
- IDs 0 to 15 are software interrupts. Each processor has its own per-source pending masks for them.
- IDs 16 to 31 are private peripheral interrupts, held in a per-processor pending vector.
- IDs from 32 upward are shared interrupts. They use a single pending vector and are filtered by a per-interrupt target byte.

Enables, priorities and groups for IDs 0 to 31 are banked per processor. For IDs 32 and up they are global.

When the scan ends, each processor's result is latched: the winning ID and its priority. The interrupt line is raised only when the winner's priority passes that processor's priority mask and both the distributor and the processor interface are enabled. The line is either the fast line or the normal line, chosen by the winner's group. The results then hold until the next scan ends.

Top module: `irqsel_top`

## Requirements
- R1: After reset, `done`, `irq` and `fiq` are low, every `win_id` field reads 1023 and every `win_prio` field reads 255.
- R2: A `start` sampled while idle begins a scan of TOTAL = 32 + NUM_SPI IDs. `done` is a one-cycle pulse visible exactly TOTAL clock edges after the edge that sampled `start`. Outputs change only at that edge and hold until the next scan ends.
- R3: The selected ID is the pending, enabled, routed ID with the numerically lowest 8-bit priority. Among equal priorities the lower ID wins.
- R4: Software ID s (0..15) is pending for processor c when any bit of `sgi_src[((c*16+s)*NUM_CPU) +: NUM_CPU]` is set. Its enable, priority and group are the banked fields for ID s.
- R5: Private ID 16+i is pending for processor c when `ppi_pend[c*16+i]` is set. Banked fields for any ID n < 32 sit at `bank_en[c*32+n]`, `bank_grp[c*32+n]` and `bank_prio[(c*32+n)*8 +: 8]`.
- R6: Shared ID 32+k uses `spi_pend[k]`, `spi_en[k]`, `spi_grp[k]` and `spi_prio[k*8 +: 8]`. It is considered for processor c only when `spi_tgt[k*8+c]` is set.
- R7: If no ID qualifies, the result is ID 1023 with priority 255 and both lines low. A priority of 255 can never be selected.
- R8: A line is raised only when the winner's priority is strictly below `pmask[c*8 +: 8]`. Equal priority raises nothing.
- R9: A group-0 winner (group bit 0) drives `fiq[c]` when `fiq_en[c]` is set. Every other raised winner drives `irq[c]`. The two lines are never high together.
- R10: If `dist_en` or `cpu_en[c]` is low when the scan ends, both lines of processor c stay low, but the winning ID and priority are still reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a scan when idle |
| dist_en | input | 1 | Global distributor enable |
| cpu_en | input | NUM_CPU | Per-processor interface enable |
| fiq_en | input | NUM_CPU | Per-processor fast-line routing enable for group 0 |
| pmask | input | NUM_CPU*8 | Per-processor priority mask |
| sgi_src | input | NUM_CPU*16*NUM_CPU | Software interrupt source masks per processor and ID |
| ppi_pend | input | NUM_CPU*16 | Private peripheral pending bits |
| bank_en | input | NUM_CPU*32 | Banked enables for IDs 0..31 |
| bank_grp | input | NUM_CPU*32 | Banked group bits for IDs 0..31 |
| bank_prio | input | NUM_CPU*256 | Banked priorities for IDs 0..31 |
| spi_pend | input | NUM_SPI | Shared pending bits |
| spi_en | input | NUM_SPI | Shared enables |
| spi_grp | input | NUM_SPI | Shared group bits |
| spi_prio | input | NUM_SPI*8 | Shared priorities |
| spi_tgt | input | NUM_SPI*8 | Shared target bytes, bit c selects processor c |
| done | output | 1 | Scan-complete pulse |
| win_id | output | NUM_CPU*10 | Winning ID per processor |
| win_prio | output | NUM_CPU*8 | Winning priority per processor |
| irq | output | NUM_CPU | Normal interrupt line per processor |
| fiq | output | NUM_CPU | Fast interrupt line per processor |

## Verification
The bench builds the block with NUM_CPU = 2 and NUM_SPI = 32, so one scan covers 64 IDs in 64 cycles. At that size a reference selection can be recomputed in full for both processors after every scan. Two processors are enough to show target-byte filtering, banked fields and per-processor masks diverging. Directed scans pin the tie, 255-priority, mask-equality, routing and enable corners. A long run of pseudo-random fills with deliberately clustered priorities then forces frequent ties across all three ID classes.

// File: rtl/irqsel_pkg.sv
package irqsel_pkg;
  localparam int PRIO_W   = 8;
  localparam int ID_W     = 10;
  localparam int BANK_IDS = 32;
  localparam int SGI_IDS  = 16;
  localparam logic [ID_W-1:0]   NO_ID   = 10'd1023;
  localparam logic [PRIO_W-1:0] IDLE_PR = 8'hFF;
endpackage

// File: rtl/irqsel_scan_ctl.sv
module irqsel_scan_ctl #(
  parameter int TOTAL = 96,
  localparam int IDXW = $clog2(TOTAL)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            busy,
  output logic [IDXW-1:0] idx,
  output logic            first,
  output logic            last,
  output logic            done
);
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(TOTAL - 1);

  logic            busy_q, busy_d, done_q, done_d, ce;
  logic [IDXW-1:0] idx_q, idx_d;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    done_d = 1'b0;
    if (!busy_q && start) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (busy_q) begin
      if (idx_q == LAST_IDX) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  assign ce = start | busy_q | done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else if (ce) begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      done_q <= done_d;
    end
  end

  assign busy  = busy_q;
  assign idx   = idx_q;
  assign first = busy_q && (idx_q == '0);
  assign last  = busy_q && (idx_q == LAST_IDX);
  assign done  = done_q;
endmodule

// File: rtl/irqsel_cpu_pick.sv
module irqsel_cpu_pick
  import irqsel_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int NUM_SPI = 64,
  parameter int CPU     = 0,
  localparam int TOTAL  = BANK_IDS + NUM_SPI,
  localparam int IDXW   = $clog2(TOTAL),
  localparam int SPIW   = $clog2(NUM_SPI)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        busy,
  input  logic                        first,
  input  logic                        last,
  input  logic [IDXW-1:0]             idx,
  input  logic [SGI_IDS*NUM_CPU-1:0]  sgi_src,
  input  logic [15:0]                 ppi_pend,
  input  logic [BANK_IDS-1:0]         bank_en,
  input  logic [BANK_IDS-1:0]         bank_grp,
  input  logic [BANK_IDS*PRIO_W-1:0]  bank_prio,
  input  logic [NUM_SPI-1:0]          spi_pend,
  input  logic [NUM_SPI-1:0]          spi_en,
  input  logic [NUM_SPI-1:0]          spi_grp,
  input  logic [NUM_SPI*PRIO_W-1:0]   spi_prio,
  input  logic [NUM_SPI*8-1:0]        spi_tgt,
  input  logic                        dist_en,
  input  logic                        cpu_en,
  input  logic                        fiq_en,
  input  logic [PRIO_W-1:0]           pmask,
  output logic [ID_W-1:0]             win_id,
  output logic [PRIO_W-1:0]           win_prio,
  output logic                        irq,
  output logic                        fiq
);
  logic              c_pend, c_en, c_grp, take, fire;
  logic [PRIO_W-1:0] c_prio, base_prio, nx_prio, best_prio_q, win_prio_q;
  logic [ID_W-1:0]   base_id, nx_id, best_id_q, win_id_q;
  logic              base_grp, nx_grp, best_grp_q, irq_q, fiq_q;
  logic [SPIW-1:0]   k;
  logic [4:0]        b;

  assign b = idx[4:0];
  assign k = SPIW'(idx - IDXW'(BANK_IDS));

  // candidate fetch: three classes with different storage
  always_comb begin
    if (idx < IDXW'(BANK_IDS)) begin
      c_pend = b[4] ? ppi_pend[b[3:0]]
                    : |sgi_src[int'(b[3:0])*NUM_CPU +: NUM_CPU];
      c_en   = bank_en[b];
      c_grp  = bank_grp[b];
      c_prio = bank_prio[int'(b)*PRIO_W +: PRIO_W];
    end else begin
      c_pend = spi_pend[k];
      c_en   = spi_en[k] & spi_tgt[int'(k)*8 + CPU];
      c_grp  = spi_grp[k];
      c_prio = spi_prio[int'(k)*PRIO_W +: PRIO_W];
    end
  end

  // running best, strict compare keeps the lower ID on ties
  always_comb begin
    base_prio = first ? IDLE_PR : best_prio_q;
    base_id   = first ? NO_ID   : best_id_q;
    base_grp  = first ? 1'b1    : best_grp_q;
    take      = busy & c_pend & c_en & (c_prio < base_prio);
    nx_prio   = take ? c_prio       : base_prio;
    nx_id     = take ? ID_W'(idx)   : base_id;
    nx_grp    = take ? c_grp        : base_grp;
    fire      = dist_en & cpu_en & (nx_prio < pmask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_prio_q <= IDLE_PR;
      best_id_q   <= NO_ID;
      best_grp_q  <= 1'b1;
    end else if (busy) begin
      best_prio_q <= nx_prio;
      best_id_q   <= nx_id;
      best_grp_q  <= nx_grp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_prio_q <= IDLE_PR;
      win_id_q   <= NO_ID;
      irq_q      <= 1'b0;
      fiq_q      <= 1'b0;
    end else if (last) begin
      win_prio_q <= nx_prio;
      win_id_q   <= nx_id;
      fiq_q      <= fire & ~nx_grp & fiq_en;
      irq_q      <= fire & ~(~nx_grp & fiq_en);
    end
  end

  assign win_id   = win_id_q;
  assign win_prio = win_prio_q;
  assign irq      = irq_q;
  assign fiq      = fiq_q;
endmodule

// File: rtl/irqsel_top.sv
module irqsel_top
  import irqsel_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int NUM_SPI = 64,
  localparam int TOTAL  = BANK_IDS + NUM_SPI,
  localparam int IDXW   = $clog2(TOTAL)
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                start,
  input  logic                                dist_en,
  input  logic [NUM_CPU-1:0]                  cpu_en,
  input  logic [NUM_CPU-1:0]                  fiq_en,
  input  logic [NUM_CPU*PRIO_W-1:0]           pmask,
  input  logic [NUM_CPU*SGI_IDS*NUM_CPU-1:0]  sgi_src,
  input  logic [NUM_CPU*16-1:0]               ppi_pend,
  input  logic [NUM_CPU*BANK_IDS-1:0]         bank_en,
  input  logic [NUM_CPU*BANK_IDS-1:0]         bank_grp,
  input  logic [NUM_CPU*BANK_IDS*PRIO_W-1:0]  bank_prio,
  input  logic [NUM_SPI-1:0]                  spi_pend,
  input  logic [NUM_SPI-1:0]                  spi_en,
  input  logic [NUM_SPI-1:0]                  spi_grp,
  input  logic [NUM_SPI*PRIO_W-1:0]           spi_prio,
  input  logic [NUM_SPI*8-1:0]                spi_tgt,
  output logic                                done,
  output logic [NUM_CPU*ID_W-1:0]             win_id,
  output logic [NUM_CPU*PRIO_W-1:0]           win_prio,
  output logic [NUM_CPU-1:0]                  irq,
  output logic [NUM_CPU-1:0]                  fiq
);
  logic            busy, first, last;
  logic [IDXW-1:0] idx;

  irqsel_scan_ctl #(.TOTAL(TOTAL)) u_ctl (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .idx(idx),
    .first(first), .last(last), .done(done)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    irqsel_cpu_pick #(.NUM_CPU(NUM_CPU), .NUM_SPI(NUM_SPI), .CPU(c)) u_pick (
      .clk(clk), .rst_n(rst_n), .busy(busy), .first(first), .last(last),
      .idx(idx),
      .sgi_src(sgi_src[c*SGI_IDS*NUM_CPU +: SGI_IDS*NUM_CPU]),
      .ppi_pend(ppi_pend[c*16 +: 16]),
      .bank_en(bank_en[c*BANK_IDS +: BANK_IDS]),
      .bank_grp(bank_grp[c*BANK_IDS +: BANK_IDS]),
      .bank_prio(bank_prio[c*BANK_IDS*PRIO_W +: BANK_IDS*PRIO_W]),
      .spi_pend(spi_pend), .spi_en(spi_en), .spi_grp(spi_grp),
      .spi_prio(spi_prio), .spi_tgt(spi_tgt),
      .dist_en(dist_en), .cpu_en(cpu_en[c]), .fiq_en(fiq_en[c]),
      .pmask(pmask[c*PRIO_W +: PRIO_W]),
      .win_id(win_id[c*ID_W +: ID_W]),
      .win_prio(win_prio[c*PRIO_W +: PRIO_W]),
      .irq(irq[c]), .fiq(fiq[c])
    );
  end
endmodule

// File: rtl/irqsel_top_chk.sv
module irqsel_top_chk #(
  parameter int NUM_CPU = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  done,
  input logic                  dist_en,
  input logic [NUM_CPU-1:0]    cpu_en,
  input logic [NUM_CPU*8-1:0]  pmask,
  input logic [NUM_CPU*10-1:0] win_id,
  input logic [NUM_CPU*8-1:0]  win_prio,
  input logic [NUM_CPU-1:0]    irq,
  input logic [NUM_CPU-1:0]    fiq
);
  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(win_id) && $stable(win_prio) && $stable(irq) && $stable(fiq)));

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_c
    // R9
    line_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({irq[c], fiq[c]}) <= 1);

    // R8
    mask_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (irq[c] || fiq[c])) |-> (win_prio[c*8 +: 8] < $past(pmask[c*8 +: 8])));

    // R10
    enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !($past(dist_en) && $past(cpu_en[c]))) |-> !(irq[c] || fiq[c]));

    // R7
    none_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ((win_id[c*10 +: 10] == 10'd1023) == (win_prio[c*8 +: 8] == 8'hFF)));
  end
endmodule

bind irqsel_top irqsel_top_chk #(.NUM_CPU(NUM_CPU)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .dist_en(dist_en), .cpu_en(cpu_en),
  .pmask(pmask), .win_id(win_id), .win_prio(win_prio), .irq(irq), .fiq(fiq)
);

// File: tb/irqsel_top_test.sv
module irqsel_top_test;
  localparam int NC = 2;
  localparam int NS = 32;
  localparam int TOT = 32 + NS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic dist_en;
  logic [NC-1:0] cpu_en, fiq_en, irq, fiq;
  logic [NC*8-1:0] pmask, win_prio;
  logic [NC*16*NC-1:0] sgi_src;
  logic [NC*16-1:0] ppi_pend;
  logic [NC*32-1:0] bank_en, bank_grp;
  logic [NC*256-1:0] bank_prio;
  logic [NS-1:0] spi_pend, spi_en, spi_grp;
  logic [NS*8-1:0] spi_prio, spi_tgt;
  logic done;
  logic [NC*10-1:0] win_id;

  int checks = 0, fails = 0;
  logic [31:0] rs = 32'h1234_5678;

  always #2.5 clk = ~clk;

  irqsel_top #(.NUM_CPU(NC), .NUM_SPI(NS)) uut (.*);

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  function automatic logic [31:0] rnd();
    rs = rs ^ (rs << 13); rs = rs ^ (rs >> 17); rs = rs ^ (rs << 5);
    return rs;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_all();
    dist_en = 1; cpu_en = '1; fiq_en = '0; pmask = '1;
    sgi_src = '0; ppi_pend = '0; bank_en = '0; bank_grp = '1; bank_prio = '1;
    spi_pend = '0; spi_en = '0; spi_grp = '1; spi_prio = '1; spi_tgt = '0;
  endtask

  // reference selection for processor c, from R3..R7
  task automatic model(int c, output int eid, output int epr, output int eirq, output int efiq);
    int g;
    eid = 1023; epr = 255; g = 1;
    for (int n = 0; n < TOT; n++) begin
      int p, e, pr, gr;
      if (n < 16) begin
        p = |sgi_src[(c*16+n)*NC +: NC];
      end else if (n < 32) begin
        p = ppi_pend[c*16+n-16];
      end
      if (n < 32) begin
        e = bank_en[c*32+n]; gr = bank_grp[c*32+n]; pr = bank_prio[(c*32+n)*8 +: 8];
      end else begin
        p = spi_pend[n-32]; e = spi_en[n-32] & spi_tgt[(n-32)*8+c];
        gr = spi_grp[n-32]; pr = spi_prio[(n-32)*8 +: 8];
      end
      if (p != 0 && e != 0 && pr < epr) begin eid = n; epr = pr; g = gr; end
    end
    eirq = 0; efiq = 0;
    if (dist_en && cpu_en[c] && epr < pmask[c*8 +: 8]) begin
      if (g == 0 && fiq_en[c]) efiq = 1; else eirq = 1;
    end
  endtask

  task automatic scan_and_check(string req);
    int cnt, eid, epr, ei, ef;
    logic [NC*10-1:0] id_snap;
    start = 1;
    @(negedge clk);
    start = 0;
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (!done && cnt < 4*TOT);
    chk("R2", "scan length", cnt, TOT);
    for (int c = 0; c < NC; c++) begin
      model(c, eid, epr, ei, ef);
      chk(req, $sformatf("cpu%0d id", c), int'(win_id[c*10 +: 10]), eid);
      chk(req, $sformatf("cpu%0d prio", c), int'(win_prio[c*8 +: 8]), epr);
      chk(req, $sformatf("cpu%0d irq", c), int'(irq[c]), ei);
      chk(req, $sformatf("cpu%0d fiq", c), int'(fiq[c]), ef);
    end
    id_snap = win_id;
    @(negedge clk);
    chk("R2", "done width", int'(done), 0);
    chk("R2", "hold id", int'(win_id == id_snap), 1);
  endtask

  initial begin
    clear_all();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "done", int'(done), 0);
    chk("R1", "lines", int'({irq, fiq}), 0);
    chk("R1", "id0", int'(win_id[9:0]), 1023);
    chk("R1", "prio1", int'(win_prio[15:8]), 255);
    rst_n = 1;
    @(negedge clk);

    // R7 nothing pending; priority 255 never wins
    scan_and_check("R7");
    spi_pend[3] = 1; spi_en[3] = 1; spi_tgt[3*8 +: 8] = 8'h03;
    scan_and_check("R7");

    // R3 tie resolves to lower ID; R6 shared class
    clear_all();
    spi_pend[8] = 1; spi_en[8] = 1; spi_tgt[8*8 +: 8] = 8'h03; spi_prio[8*8 +: 8] = 8'h20;
    spi_pend[3] = 1; spi_en[3] = 1; spi_tgt[3*8 +: 8] = 8'h03; spi_prio[3*8 +: 8] = 8'h20;
    scan_and_check("R3");

    // R6 target byte excludes processor 0
    spi_pend[1] = 1; spi_en[1] = 1; spi_tgt[1*8 +: 8] = 8'h02; spi_prio[1*8 +: 8] = 8'h00;
    scan_and_check("R6");

    // R4 software source mask, source bit 1 only, for cpu1 ID 5
    sgi_src[(1*16+5)*NC +: NC] = 2'b10;
    bank_en[1*32+5] = 1; bank_prio[(1*32+5)*8 +: 8] = 8'h00;
    // R5 private ID 20 for cpu0
    ppi_pend[0*16+4] = 1; bank_en[0*32+20] = 1; bank_prio[(0*32+20)*8 +: 8] = 8'h01;
    scan_and_check("R4");
    scan_and_check("R5");

    // R8 priority equal to mask raises nothing, one above raises
    pmask = {8'h00, 8'h01};
    scan_and_check("R8");
    pmask = {8'h01, 8'h02};
    scan_and_check("R8");

    // R9 group 0 to fast line when enabled
    bank_grp[0*32+20] = 0; fiq_en = 2'b01;
    scan_and_check("R9");
    fiq_en = 2'b00;
    scan_and_check("R9");

    // R10 disables gate lines but keep the ID
    dist_en = 0;
    scan_and_check("R10");
    dist_en = 1; cpu_en = 2'b10;
    scan_and_check("R10");

    // R3/R4/R5/R6/R9 sweep with clustered priorities
    for (int t = 0; t < 60; t++) begin
      sgi_src = {rnd(), rnd()};
      ppi_pend = rnd(); bank_en = {rnd(), rnd()}; bank_grp = {rnd(), rnd()};
      for (int i = 0; i < NC*32; i++) bank_prio[i*8 +: 8] = {2'b00, rnd() % 8, 3'b000} | 8'(rnd() % 2);
      spi_pend = rnd() & rnd(); spi_en = rnd(); spi_grp = rnd();
      for (int i = 0; i < NS; i++) begin
        spi_prio[i*8 +: 8] = (rnd() % 5 == 0) ? 8'hFF : 8'(rnd() % 16);
        spi_tgt[i*8 +: 8] = 8'(rnd());
      end
      if (t % 3 == 0) begin sgi_src = '0; ppi_pend = '0; end
      dist_en = (t % 7 != 6); cpu_en = 2'(rnd()) | 2'(t % 2 + 1);
      fiq_en = 2'(rnd()); pmask = {8'(rnd() % 40), 8'(rnd() % 40)};
      scan_and_check("R3");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule